// File: doc/BRIEF.md
# Cyclic Ring DMA Channel

This block is one DMA channel that streams 32-bit words endlessly around a ring buffer in system memory. On the other side of the ring is a peripheral FIFO. The channel runs in one of two directions. In memory-to-peripheral mode it reads words from the ring and hands them to the peripheral. In peripheral-to-memory mode it takes words from the peripheral and writes them into the ring. The ring is made of one to eight equal periods. When the last word of the last period has been moved, the memory address goes back to the ring base.

Software sets the channel up through a small register window on a simple 32-bit write/read bus. The window holds the period length in bytes, the ring base address, the period count, the direction and a few stored tuning fields. Software then starts the channel with a command write. Each finished period raises an interrupt and advances a free-running 16-bit period counter, which software unwraps. A live register shows how many bytes are still left in the current period. A command write of zero requests a stop. The status busy bit drops only when the channel has really stopped.

Top module: `ring_dma_channel`

## Requirements
- R1: After reset the status busy bit (offset 0x0C, bit 0) is 0. The interrupt status (offset 0x10, bit 0), the `irq` output, the period counter (0x54) and the remaining-bytes register (0x30) all read 0, and no memory or peripheral beat is offered.
- R2: Writing 1 to bit 0 of the command register (0x00) while idle starts the channel, and the busy bit reads 1 from the next cycle. The start is ignored, and busy stays 0, when the direction field (control 0x24, bits [15:12]) is neither 4 (memory-to-peripheral) nor 2 (peripheral-to-memory), or when the period length is zero.
- R3: In memory-to-peripheral mode, the words at memory base + 4k are delivered to the peripheral in increasing k. After periods × length bytes the address returns to the base, so the data order repeats across ring wraps. The base is the source address register (0x34).
- R4: In peripheral-to-memory mode, the words taken from the peripheral are written in arrival order to memory base + 4k, wrapping the same way. The base is the target address register (0x3C).
- R5: The period length register (0x44) keeps only bits [29:2], and the source and target address registers force bits [1:0] to 0, so every length and memory access is 4-byte aligned.
- R6: When the destination accepts the final word of a period, interrupt status bit 0 and `irq` are set at that clock edge. Writing 1 to bit 0 of the clear register (0x1C) clears them.
- R7: The period counter (0x54) is cleared by a start, increments by one per completed period, and wraps from 0xFFFF to 0.
- R8: The remaining-bytes register (0x30) equals the period length right after a start. It drops by 4 for each word the destination accepts and reloads to the period length when a period completes.
- R9: Writing 0 to the command bit while busy stops the channel. A word already fetched is still delivered to its destination. A peripheral-to-memory channel waiting for input stops without taking another word. After busy falls, no memory or peripheral beat is offered.
- R10: While busy, writes to any register other than the command register (0x00) and the interrupt clear register (0x1C) are ignored.
- R11: The period count comes from config (0x28) bits [30:28] + 1 in memory-to-peripheral mode and from bits [26:24] + 1 in peripheral-to-memory mode. The field for the other direction has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_valid | output | 1 | Memory beat request, held until `mem_ready` |
| mem_ready | input | 1 | Memory accepts the beat this cycle |
| mem_write | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |
| per_tx_valid | output | 1 | Word offered to the peripheral |
| per_tx_ready | input | 1 | Peripheral accepts the word |
| per_tx_data | output | 32 | Word to the peripheral |
| per_rx_valid | input | 1 | Peripheral offers a word |
| per_rx_ready | output | 1 | Channel takes the offered word |
| per_rx_data | input | 32 | Word from the peripheral |
| irq | output | 1 | Period-complete interrupt |

## Verification
A wrong ring walk shows up at the ports as a reordered or repeated word. In memory-to-peripheral mode this is visible in the first word past the ring end. In peripheral-to-memory mode it shows as a ring slot holding a stale or foreign value, or a write landing past the ring. A broken period tally is caught by comparing the counter and the remaining-bytes register with the number of beats the bench itself saw accepted. A missed or early interrupt edge is caught in the cycle after the last word of the period. Two cases need long or stalled runs: the 16-bit counter wrap, and the stop that lands while a stalled beat is held. The bench drives both on purpose.

// File: rtl/ring_dma_pkg.sv
// Shared constants and types for the cyclic ring DMA channel.
// Assumes a channel register window of 128 bytes addressed by byte offset.
package ring_dma_pkg;
    localparam logic [7:0] OFF_CMD    = 8'h00;
    localparam logic [7:0] OFF_STATUS = 8'h0C;
    localparam logic [7:0] OFF_INTST  = 8'h10;
    localparam logic [7:0] OFF_INTCLR = 8'h1C;
    localparam logic [7:0] OFF_CTRL   = 8'h24;
    localparam logic [7:0] OFF_CFG    = 8'h28;
    localparam logic [7:0] OFF_FIFO   = 8'h2C;
    localparam logic [7:0] OFF_REMAIN = 8'h30;
    localparam logic [7:0] OFF_SRC    = 8'h34;
    localparam logic [7:0] OFF_TRG    = 8'h3C;
    localparam logic [7:0] OFF_LEN    = 8'h44;
    localparam logic [7:0] OFF_PCOUNT = 8'h54;

    localparam logic [3:0] DIR_P2M = 4'd2;
    localparam logic [3:0] DIR_M2P = 4'd4;

    localparam logic [31:0] LEN_MASK  = 32'h3FFF_FFFC;
    localparam logic [31:0] CTRL_MASK = 32'h0000_F302;
    localparam logic [31:0] CFG_MASK  = 32'h7770_000F;
    localparam logic [31:0] FIFO_MASK = 32'h0F0F_0F0F;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_PUSH
    } chan_state_t;
endpackage

// File: rtl/ring_dma_regs.sv
// Register bank of the ring DMA channel.
// Holds the set-up fields, the run request and the interrupt flag.
// Assumes set-up fields must not move under a running channel, so it
// blocks their writes while busy. Reads are combinational.
module ring_dma_regs
    import ring_dma_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic              period_done,
    input  logic [31:0]       remain,
    input  logic [CNT_W-1:0]  pcount,
    output logic              start,
    output logic              stop_req,
    output logic              dir_m2p,
    output logic [31:0]       mem_base,
    output logic [31:0]       len_bytes,
    output logic [2:0]        nbufs_m1,
    output logic              irq
);
    logic        run_q;
    logic        int_q;
    logic [31:0] ctrl_q, cfg_q, fifo_q, src_q, trg_q, len_q;
    logic        dir_ok, cfg_wr;

    // Decode the direction and the accepted start condition.
    always_comb begin
        dir_ok   = (ctrl_q[15:12] == DIR_M2P) || (ctrl_q[15:12] == DIR_P2M);
        start    = reg_wr && (reg_addr == ADDR_W'(OFF_CMD)) && reg_wdata[0]
                   && !busy && dir_ok && (len_q != '0);
        cfg_wr   = reg_wr && !busy;
        dir_m2p  = (ctrl_q[15:12] == DIR_M2P);
        mem_base = dir_m2p ? src_q : trg_q;
        nbufs_m1 = dir_m2p ? cfg_q[30:28] : cfg_q[26:24];
        len_bytes = len_q;
        stop_req = !run_q;
        irq      = int_q;
    end

    // Store run request, set-up fields and interrupt flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            int_q  <= 1'b0;
            ctrl_q <= '0;
            cfg_q  <= '0;
            fifo_q <= '0;
            src_q  <= '0;
            trg_q  <= '0;
            len_q  <= '0;
        end else begin
            if (reg_wr && (reg_addr == ADDR_W'(OFF_CMD)))
                run_q <= reg_wdata[0] && (busy || start);
            if (period_done)
                int_q <= 1'b1;
            else if (reg_wr && (reg_addr == ADDR_W'(OFF_INTCLR)) && reg_wdata[0])
                int_q <= 1'b0;
            if (cfg_wr) begin
                case (reg_addr)
                    ADDR_W'(OFF_CTRL): ctrl_q <= reg_wdata & CTRL_MASK;
                    ADDR_W'(OFF_CFG):  cfg_q  <= reg_wdata & CFG_MASK;
                    ADDR_W'(OFF_FIFO): fifo_q <= reg_wdata & FIFO_MASK;
                    ADDR_W'(OFF_SRC):  src_q  <= {reg_wdata[31:2], 2'b00};
                    ADDR_W'(OFF_TRG):  trg_q  <= {reg_wdata[31:2], 2'b00};
                    ADDR_W'(OFF_LEN):  len_q  <= reg_wdata & LEN_MASK;
                    default: ;
                endcase
            end
        end
    end

    // Read multiplexer over the register window.
    always_comb begin
        case (reg_addr)
            ADDR_W'(OFF_CMD):    reg_rdata = {31'b0, run_q};
            ADDR_W'(OFF_STATUS): reg_rdata = {31'b0, busy};
            ADDR_W'(OFF_INTST):  reg_rdata = {31'b0, int_q};
            ADDR_W'(OFF_CTRL):   reg_rdata = ctrl_q;
            ADDR_W'(OFF_CFG):    reg_rdata = cfg_q;
            ADDR_W'(OFF_FIFO):   reg_rdata = fifo_q;
            ADDR_W'(OFF_REMAIN): reg_rdata = remain;
            ADDR_W'(OFF_SRC):    reg_rdata = src_q;
            ADDR_W'(OFF_TRG):    reg_rdata = trg_q;
            ADDR_W'(OFF_LEN):    reg_rdata = len_q;
            ADDR_W'(OFF_PCOUNT): reg_rdata = 32'(pcount);
            default:             reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ring_dma_engine.sv
// Transfer engine of the ring DMA channel.
// Moves one word at a time: a fetch from the source side, then a push to
// the destination side. It walks the memory address over the ring of
// periods and tallies periods. Assumes the set-up inputs are stable while
// busy, and that memory read data is valid in the cycle of mem_ready.
module ring_dma_engine
    import ring_dma_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop_req,
    input  logic             dir_m2p,
    input  logic [31:0]      mem_base,
    input  logic [31:0]      len_bytes,
    input  logic [2:0]       nbufs_m1,
    output logic             mem_valid,
    input  logic             mem_ready,
    output logic             mem_write,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    output logic             per_tx_valid,
    input  logic             per_tx_ready,
    output logic [31:0]      per_tx_data,
    input  logic             per_rx_valid,
    output logic             per_rx_ready,
    input  logic [31:0]      per_rx_data,
    output logic             busy,
    output logic             period_done,
    output logic [31:0]      remain,
    output logic [CNT_W-1:0] pcount
);
    localparam logic [31:0] WORD_BYTES = 32'd4;

    chan_state_t state;
    logic [31:0] offset;
    logic [2:0]  buf_idx;
    logic [31:0] hold;
    logic        fetching, pushing, fetch_done, push_done;

    // Handshake outputs and beat completion for the current state.
    always_comb begin
        fetching     = (state == ST_FETCH);
        pushing      = (state == ST_PUSH);
        busy         = (state != ST_IDLE);
        mem_valid    = (fetching && dir_m2p) || (pushing && !dir_m2p);
        mem_write    = pushing && !dir_m2p;
        mem_addr     = mem_base + offset;
        mem_wdata    = hold;
        per_tx_valid = pushing && dir_m2p;
        per_tx_data  = hold;
        per_rx_ready = fetching && !dir_m2p && !stop_req;
        fetch_done   = fetching && (dir_m2p ? mem_ready : (per_rx_valid && per_rx_ready));
        push_done    = pushing && (dir_m2p ? per_tx_ready : mem_ready);
        period_done  = push_done && (remain == WORD_BYTES);
    end

    // Sequence fetch and push, advance the ring walk and the period tally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            offset  <= '0;
            buf_idx <= '0;
            hold    <= '0;
            remain  <= '0;
            pcount  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state   <= ST_FETCH;
                        offset  <= '0;
                        buf_idx <= '0;
                        remain  <= len_bytes;
                        pcount  <= '0;
                    end
                end
                ST_FETCH: begin
                    if (fetch_done) begin
                        hold  <= dir_m2p ? mem_rdata : per_rx_data;
                        state <= ST_PUSH;
                    end else if (!dir_m2p && stop_req) begin
                        state <= ST_IDLE;
                    end
                end
                ST_PUSH: begin
                    if (push_done) begin
                        if (period_done) begin
                            remain <= len_bytes;
                            pcount <= pcount + 1'b1;
                            if (buf_idx == nbufs_m1) begin
                                buf_idx <= '0;
                                offset  <= '0;
                            end else begin
                                buf_idx <= buf_idx + 1'b1;
                                offset  <= offset + WORD_BYTES;
                            end
                        end else begin
                            remain <= remain - WORD_BYTES;
                            offset <= offset + WORD_BYTES;
                        end
                        state <= stop_req ? ST_IDLE : ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ring_dma_channel.sv
// Top of the cyclic ring DMA channel: register bank plus transfer engine.
// Assumes a single clock domain, and a memory and peripheral that follow
// valid/ready handshakes.
module ring_dma_channel #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_write,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              per_tx_valid,
    input  logic              per_tx_ready,
    output logic [31:0]       per_tx_data,
    input  logic              per_rx_valid,
    output logic              per_rx_ready,
    input  logic [31:0]       per_rx_data,
    output logic              irq
);
    logic             busy, period_done, start, stop_req, dir_m2p;
    logic [31:0]      remain, mem_base, len_bytes;
    logic [CNT_W-1:0] pcount;
    logic [2:0]       nbufs_m1;

    ring_dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .period_done(period_done), .remain(remain), .pcount(pcount),
        .start(start), .stop_req(stop_req), .dir_m2p(dir_m2p),
        .mem_base(mem_base), .len_bytes(len_bytes), .nbufs_m1(nbufs_m1),
        .irq(irq)
    );

    ring_dma_engine #(.CNT_W(CNT_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .stop_req(stop_req),
        .dir_m2p(dir_m2p), .mem_base(mem_base), .len_bytes(len_bytes),
        .nbufs_m1(nbufs_m1), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .per_tx_valid(per_tx_valid),
        .per_tx_ready(per_tx_ready), .per_tx_data(per_tx_data),
        .per_rx_valid(per_rx_valid), .per_rx_ready(per_rx_ready),
        .per_rx_data(per_rx_data), .busy(busy), .period_done(period_done),
        .remain(remain), .pcount(pcount)
    );
endmodule

// File: rtl/ring_dma_checker.sv
// Protocol and state checker for ring_dma_channel, attached by bind.
// Assumes it sees the top's internal busy, remain, pcount and len_bytes.
module ring_dma_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             irq,
    input logic             mem_valid,
    input logic             mem_ready,
    input logic             mem_write,
    input logic [31:0]      mem_addr,
    input logic             per_tx_valid,
    input logic             per_tx_ready,
    input logic [31:0]      per_tx_data,
    input logic             per_rx_ready,
    input logic [31:0]      remain,
    input logic [31:0]      len_bytes,
    input logic [CNT_W-1:0] pcount
);
    // A stalled memory beat keeps its request, direction and address.
    assert_mem_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write));

    // A stalled peripheral word keeps its data.
    assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        per_tx_valid && !per_tx_ready |=> per_tx_valid && $stable(per_tx_data));

    // Memory accesses stay word aligned.
    assert_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_addr[1:0] == 2'b00);

    // The interrupt rises only together with a period tally step.
    assert_irq_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> pcount == CNT_W'($past(pcount) + 1'b1));

    // While running, the period tally only moves forward by one.
    assert_pcount_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && (pcount != $past(pcount)) |-> pcount == CNT_W'($past(pcount) + 1'b1));

    // While running, the remaining bytes stay within one non-empty period.
    assert_remain_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (remain != 32'd0) && (remain <= len_bytes));

    // An idle channel offers no beat on either side.
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_valid && !per_tx_valid && !per_rx_ready);
endmodule

bind ring_dma_channel ring_dma_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
    .per_tx_valid(per_tx_valid), .per_tx_ready(per_tx_ready),
    .per_tx_data(per_tx_data), .per_rx_ready(per_rx_ready), .remain(remain),
    .len_bytes(len_bytes), .pcount(pcount)
);

// File: tb/ring_dma_channel_tb.sv
// Bench for ring_dma_channel: behavioural memory and peripheral models with
// random stalls from a fixed seed, plus directed corner cases.
module ring_dma_channel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_valid, mem_write, per_tx_valid, per_rx_ready, irq;
    logic        mem_ready = 1'b0, per_tx_ready = 1'b0, per_rx_valid = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, per_tx_data, per_rx_data;

    int checks = 0, bad = 0;
    int tx_n = 0, rx_n = 0, idle_beats = 0;
    bit stall_en = 1'b1, finished = 1'b0;
    logic [31:0] mem [0:63];
    bit          written [0:63];
    logic [31:0] tx_log [0:63];

    always #2 clk = ~clk;

    ring_dma_channel u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .per_tx_valid(per_tx_valid), .per_tx_ready(per_tx_ready),
        .per_tx_data(per_tx_data), .per_rx_valid(per_rx_valid),
        .per_rx_ready(per_rx_ready), .per_rx_data(per_rx_data), .irq(irq)
    );

    function automatic logic [31:0] init_pat(input int idx);
        return 32'hA500_0000 | (32'(idx) << 8) | 32'(idx);
    endfunction

    function automatic logic [31:0] mem_word(input int idx);
        return written[idx] ? mem[idx] : init_pat(idx);
    endfunction

    assign mem_rdata   = mem_word(int'(mem_addr[7:2]));
    assign per_rx_data = 32'hC0DE_0000 + 32'(rx_n);

    // Memory and peripheral models: record every accepted beat.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) written[i] <= 1'b0;
        end else begin
            if (mem_valid && mem_ready && mem_write) begin
                mem[mem_addr[7:2]]     <= mem_wdata;
                written[mem_addr[7:2]] <= 1'b1;
            end
            if (per_tx_valid && per_tx_ready) begin
                tx_log[tx_n % 64] <= per_tx_data;
                tx_n <= tx_n + 1;
            end
            if (per_rx_valid && per_rx_ready) rx_n <= rx_n + 1;
            if (!u_dut.busy && (mem_valid || per_tx_valid || per_rx_ready))
                idle_beats <= idle_beats + 1;
        end
    end

    // Random stall pattern, changed away from the active edge.
    always @(negedge clk) begin
        mem_ready    <= stall_en ? ($urandom % 4 != 0) : 1'b1;
        per_tx_ready <= stall_en ? ($urandom % 3 != 0) : 1'b1;
        per_rx_valid <= stall_en ? ($urandom % 3 != 0) : 1'b1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            rd(8'h0C, s);
            if (s[0] == 1'b0) return;
            @(negedge clk);
        end
    endtask

    task automatic wait_tx(input int target);
        for (int i = 0; i < 180000; i++) begin
            if (tx_n >= target) return;
            @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            checks++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int base, n, k, idle0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(8'h0C, v); chk(v == 0, "R1 status", v, 0);
        rd(8'h10, v); chk(v == 0, "R1 intstat", v, 0);
        rd(8'h54, v); chk(v == 0, "R1 pcount", v, 0);
        rd(8'h30, v); chk(v == 0, "R1 remain", v, 0);
        chk(!irq && !mem_valid && !per_tx_valid && !per_rx_ready, "R1 outputs",
            {irq, mem_valid, per_tx_valid, per_rx_ready}, 0);

        // R5: length and address alignment masks
        wr(8'h44, 32'hFFFF_FFFF); rd(8'h44, v); chk(v == 32'h3FFF_FFFC, "R5 length mask", v, 32'h3FFF_FFFC);
        wr(8'h34, 32'h0000_0043); rd(8'h34, v); chk(v == 32'h40, "R5 addr align", v, 32'h40);

        // R2: start rejected with bad direction, then with zero length
        wr(8'h44, 32'd8); wr(8'h24, 32'h0000_0202); wr(8'h00, 1);
        rd(8'h0C, v); chk(v == 0, "R2 bad direction start", v, 0);
        wr(8'h00, 0); wr(8'h44, 32'd0); wr(8'h24, 32'h0000_4202); wr(8'h00, 1);
        rd(8'h0C, v); chk(v == 0, "R2 zero length start", v, 0);
        wr(8'h00, 0);

        // R3/R11: memory-to-peripheral, 3 periods of 8 bytes at 0x40, stalls on
        wr(8'h44, 32'd8);
        wr(8'h28, (32'd2 << 28) | (32'd5 << 24) | (32'd5 << 20) | 32'd1);
        wr(8'h24, 32'h0000_4202);
        base = tx_n;
        wr(8'h00, 1);
        rd(8'h0C, v); chk(v == 1, "R2 busy after start", v, 1);
        rd(8'h30, v); chk(v == 8, "R8 remain at start", v, 8);
        wr(8'h44, 32'h100); rd(8'h44, v); chk(v == 8, "R10 write ignored while busy", v, 8);
        wait_tx(base + 14);
        wr(8'h00, 0);
        wait_idle();
        n = tx_n - base;
        chk(n >= 14 && n < 64, "R9 word count after stop", 32'(n), 14);
        for (int i = 0; i < n; i++)
            chk(tx_log[(base + i) % 64] == init_pat(16 + (i % 6)), "R3 ring order",
                tx_log[(base + i) % 64], init_pat(16 + (i % 6)));
        rd(8'h54, v); chk(v == 32'(n / 2), "R7 period count", v, 32'(n / 2));
        rd(8'h30, v); chk(v == 32'(8 - 4 * (n % 2)), "R8 remain after stop", v, 32'(8 - 4 * (n % 2)));
        chk(irq == 1'b1, "R6 irq set", {31'b0, irq}, 1);
        idle0 = idle_beats;
        repeat (20) @(negedge clk);
        chk(idle_beats == idle0 && tx_n == base + n, "R9 quiet after stop", 32'(tx_n - base), 32'(n));
        wr(8'h1C, 1);
        rd(8'h10, v); chk(v == 0 && !irq, "R6 clear", v, 0);

        // R4/R11: peripheral-to-memory, 2 periods of 12 bytes at 0x80, other field 7
        wr(8'h3C, 32'h80); wr(8'h44, 32'd12);
        wr(8'h28, (32'd7 << 28) | (32'd1 << 24) | (32'd5 << 20));
        wr(8'h24, 32'h0000_2202);
        base = rx_n;
        wr(8'h00, 1);
        for (int i = 0; i < 4000 && (rx_n - base) < 20; i++) @(negedge clk);
        wr(8'h00, 0);
        wait_idle();
        @(negedge clk);
        n = rx_n - base;
        chk(n >= 20, "R4 words taken", 32'(n), 20);
        for (int j = 0; j < 6; j++) begin
            k = j + 6 * ((n - 1 - j) / 6);
            chk(mem_word(32 + j) == 32'hC0DE_0000 + 32'(base + k), "R4 ring slot",
                mem_word(32 + j), 32'hC0DE_0000 + 32'(base + k));
        end
        chk(mem_word(38) == init_pat(38), "R11 nothing past ring", mem_word(38), init_pat(38));
        rd(8'h54, v); chk(v == 32'(n / 3), "R7 p2m period count", v, 32'(n / 3));
        idle0 = rx_n;
        repeat (10) @(negedge clk);
        chk(rx_n == idle0, "R9 no input taken after stop", 32'(rx_n), 32'(idle0));
        wr(8'h1C, 1);

        // R6/R7: one-word periods without stalls; irq edge timing and counter wrap
        stall_en = 1'b0;
        @(negedge clk);
        wr(8'h34, 32'h0); wr(8'h44, 32'd4);
        wr(8'h28, (32'd5 << 20)); wr(8'h24, 32'h0000_4202);
        base = tx_n;
        wr(8'h00, 1);
        for (int i = 0; i < 20 && !(per_tx_valid && per_tx_ready); i++) @(negedge clk);
        chk(irq == 1'b0, "R6 irq low before last word", {31'b0, irq}, 0);
        @(negedge clk);
        chk(irq == 1'b1, "R6 irq at period end", {31'b0, irq}, 1);
        wait_tx(base + 65537);
        wr(8'h00, 0);
        wait_idle();
        n = tx_n - base;
        rd(8'h54, v);
        chk(n > 65536 && v == 32'(n % 65536), "R7 counter wrap", v, 32'(n % 65536));

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule